// File: doc/BRIEF.md
# Standby Mode Entry Controller

This block decides when a microcontroller core leaves normal execution for one of four low-power modes, and when it comes back. Software writes a one-hot request into an 8-bit write-only control register on a simple peripheral write bus. The request names light halt, full stop, deep halt, or halt with the fast clock stopped. The controller first checks the entry conditions: the stop unlock flag, any pending enabled interrupt, and the status of the active oscillator. Only then does it change mode. In the new mode it drives the CPU clock gate and the two oscillator stop lines.

While the block is in a low-power mode, any interrupt whose enable and request bits are both set brings it back to normal execution. A one-cycle wake pulse marks the return. It carries a service flag that copies the master interrupt enable, so the core can tell a real interrupt apart from a plain release. The oscillators, the interrupt controller and the stop unlock sequence are outside the block and appear only as input signals.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset the mode is RUN (code 0). cpu_clk_en is 1, hs_clk_stop and ls_clk_stop are 0, and wake is 0.
- R2: A write from RUN to address REG_ADDR (default 16'hF009) with exactly one of data bits 3..0 set enters the matching mode at that clock edge. Bit 0 gives HALT (code 1), bit 1 gives STOP (code 2), bit 2 gives DEEP-HALT (code 3) and bit 3 gives HALT-H (code 4). Data bits 7..4 are ignored, and a write with bits 3..0 all zero leaves the mode at RUN.
- R3: A write requesting STOP is discarded while stop_unlock is 0.
- R4: A write with more than one of bits 3..0 set is discarded, and the mode stays RUN.
- R5: No entry happens while any irq_en[i] and irq_req[i] pair is 1, whatever the value of mie.
- R6: With hs_sel=1 (running from the fast oscillator), entry to STOP, DEEP-HALT or HALT-H requires hs_osc_stat=0. With hs_sel=0, entry to DEEP-HALT requires ls_osc_stat=0. HALT entry does not depend on either status flag.
- R7: cpu_clk_en is 0 in every low-power mode. hs_clk_stop is 1 in STOP, DEEP-HALT and HALT-H. ls_clk_stop is 1 only in STOP.
- R8: In a low-power mode, a pending enabled interrupt returns the mode to RUN at the next edge. wake is then 1 for exactly one cycle, and wake_svc equals mie as sampled at that edge.
- R9: Writes to any other address, and writes made while in a low-power mode, leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| stop_unlock | input | 1 | Stop acceptor enabled |
| irq_en | input | IRQ_N | Interrupt enable bits |
| irq_req | input | IRQ_N | Interrupt request bits |
| mie | input | 1 | Master interrupt enable |
| hs_sel | input | 1 | 1: system clock runs from the fast oscillator |
| hs_osc_stat | input | 1 | Fast oscillator status flag |
| ls_osc_stat | input | 1 | Slow oscillator status flag |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| hs_clk_stop | output | 1 | Stop fast oscillator |
| ls_clk_stop | output | 1 | Stop slow oscillator |
| wake | output | 1 | One-cycle return-to-RUN pulse |
| wake_svc | output | 1 | Interrupt is to be serviced (valid with wake) |

## Verification
The assertions assume that the interrupt enable and request vectors, mie and the oscillator flags are synchronous to clk and stable around each rising edge. They also assume that a write presents its address and data in the same cycle as its strobe. The bench changes every input only on the falling edge and holds it across the next rising edge. Each write strobe is held high for exactly one cycle. It raises a wake interrupt only after checking the mode that the write produced, so entry and release never fall in the same cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_HALT  = 3'd1,
    M_STOP  = 3'd2,
    M_DHALT = 3'd3,
    M_HALTH = 3'd4
  } lpm_mode_e;
endpackage

// File: rtl/lpm_pending.sv
module lpm_pending #(
  parameter int IRQ_N = 8
) (
  input  logic [IRQ_N-1:0] irq_en,
  input  logic [IRQ_N-1:0] irq_req,
  output logic             pend
);
  logic [IRQ_N-1:0] hit;
  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    assign hit[i] = irq_en[i] & irq_req[i];
  end
  assign pend = |hit;
endmodule

// File: rtl/lpm_entry_check.sv
module lpm_entry_check
  import lpm_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF009
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              stop_unlock,
  input  logic              pend,
  input  logic              hs_sel,
  input  logic              hs_osc_stat,
  input  logic              ls_osc_stat,
  output logic              enter,
  output lpm_mode_e         target
);
  logic [3:0] req;
  logic       single;
  logic       osc_ok;
  logic       unused_hi;

  assign req       = bus_wdata[3:0];
  assign unused_hi = ^bus_wdata[7:4];
  assign single    = (req != 4'd0) && ((req & (req - 4'd1)) == 4'd0);

  always_comb begin
    unique case (1'b1)
      req[1]:  target = M_STOP;
      req[2]:  target = M_DHALT;
      req[3]:  target = M_HALTH;
      default: target = M_HALT;
    endcase
  end

  always_comb begin
    osc_ok = 1'b1;
    if (hs_sel) begin
      if (target != M_HALT) osc_ok = !hs_osc_stat;
    end else begin
      if (target == M_DHALT) osc_ok = !ls_osc_stat;
    end
  end

  assign enter = bus_wr && (bus_addr == REG_ADDR) && single && !pend &&
                 ((target != M_STOP) || stop_unlock) && osc_ok;
endmodule

// File: rtl/lpm_state.sv
module lpm_state
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enter,
  input  lpm_mode_e target,
  input  logic      pend,
  input  logic      mie,
  output lpm_mode_e mode,
  output logic      cpu_clk_en,
  output logic      hs_clk_stop,
  output logic      ls_clk_stop,
  output logic      wake,
  output logic      wake_svc
);
  lpm_mode_e mode_n;
  logic      wake_n;

  always_comb begin
    mode_n = mode;
    wake_n = 1'b0;
    if (mode == M_RUN) begin
      if (enter) mode_n = target;
    end else if (pend) begin
      mode_n = M_RUN;
      wake_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= M_RUN;
      cpu_clk_en  <= 1'b1;
      hs_clk_stop <= 1'b0;
      ls_clk_stop <= 1'b0;
      wake        <= 1'b0;
      wake_svc    <= 1'b0;
    end else begin
      mode        <= mode_n;
      cpu_clk_en  <= (mode_n == M_RUN);
      hs_clk_stop <= (mode_n == M_STOP) || (mode_n == M_DHALT) || (mode_n == M_HALTH);
      ls_clk_stop <= (mode_n == M_STOP);
      wake        <= wake_n;
      wake_svc    <= wake_n & mie;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF009,
  parameter int                IRQ_N    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              stop_unlock,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              mie,
  input  logic              hs_sel,
  input  logic              hs_osc_stat,
  input  logic              ls_osc_stat,
  output logic [2:0]        mode,
  output logic              cpu_clk_en,
  output logic              hs_clk_stop,
  output logic              ls_clk_stop,
  output logic              wake,
  output logic              wake_svc
);
  logic      pend;
  logic      enter;
  lpm_mode_e target;
  lpm_mode_e mode_q;

  lpm_pending #(.IRQ_N(IRQ_N)) u_pend (
    .irq_en(irq_en), .irq_req(irq_req), .pend(pend)
  );

  lpm_entry_check #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stop_unlock(stop_unlock), .pend(pend), .hs_sel(hs_sel),
    .hs_osc_stat(hs_osc_stat), .ls_osc_stat(ls_osc_stat),
    .enter(enter), .target(target)
  );

  lpm_state u_state (
    .clk(clk), .rst(rst), .enter(enter), .target(target), .pend(pend),
    .mie(mie), .mode(mode_q), .cpu_clk_en(cpu_clk_en),
    .hs_clk_stop(hs_clk_stop), .ls_clk_stop(ls_clk_stop),
    .wake(wake), .wake_svc(wake_svc)
  );

  assign mode = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF009,
  parameter int                IRQ_N    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              stop_unlock,
  input logic [IRQ_N-1:0]  irq_en,
  input logic [IRQ_N-1:0]  irq_req,
  input logic              mie,
  input logic [2:0]        mode,
  input logic              cpu_clk_en,
  input logic              hs_clk_stop,
  input logic              ls_clk_stop,
  input logic              wake,
  input logic              wake_svc
);
  logic pending;
  logic reg_wr;
  assign pending = |(irq_en & irq_req);
  assign reg_wr  = bus_wr && (bus_addr == REG_ADDR);

  assert_wake_release_R8: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd0 && pending) |=> (mode == 3'd0 && wake && wake_svc == $past(mie)));

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  assert_stop_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && reg_wr && bus_wdata[1] && !stop_unlock) |=> (mode != 3'd2));

  assert_pending_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && pending) |=> (mode == 3'd0));

  assert_multi_discard_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && $countones(bus_wdata[3:0]) > 1) |=> (mode == 3'd0));

  assert_clk_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd0) |-> (!cpu_clk_en && (ls_clk_stop == (mode == 3'd2))));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .IRQ_N(IRQ_N)) u_lpm_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .stop_unlock(stop_unlock), .irq_en(irq_en), .irq_req(irq_req), .mie(mie),
  .mode(mode), .cpu_clk_en(cpu_clk_en), .hs_clk_stop(hs_clk_stop),
  .ls_clk_stop(ls_clk_stop), .wake(wake), .wake_svc(wake_svc)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int IRQ_N = 8;
  localparam int NV    = 13;
  // vector: [11:8] mode bits, [7] unlock, [6] pending, [5] hs_sel, [4] hs_stat, [3] ls_stat, [2:0] expected mode
  localparam logic [11:0] VEC [NV] = '{
    12'b0001_0_0_1_0_0_001,  // R2 HALT
    12'b0010_1_0_1_0_0_010,  // R2 STOP
    12'b0010_0_0_1_0_0_000,  // R3 locked
    12'b0100_0_0_1_0_0_011,  // R2 DEEP-HALT
    12'b1000_0_0_1_0_0_100,  // R2 HALT-H
    12'b0011_1_0_1_0_0_000,  // R4 multi
    12'b0000_1_0_1_0_0_000,  // R2 zero
    12'b0001_0_1_1_0_0_000,  // R5 pending
    12'b0010_1_0_1_1_0_000,  // R6 hs busy
    12'b0100_0_0_0_0_1_000,  // R6 ls busy
    12'b0100_0_0_0_1_0_011,  // R6 hs ignored on slow clock
    12'b1000_0_0_1_1_0_000,  // R6 HALT-H blocked
    12'b0001_0_0_1_1_1_001   // R6 HALT ungated
  };

  logic clk = 0, rst = 1;
  logic bus_wr = 0;
  logic [15:0] bus_addr = 16'hF009;
  logic [7:0] bus_wdata = 0;
  logic stop_unlock = 0, mie = 0, hs_sel = 1, hs_osc_stat = 0, ls_osc_stat = 0;
  logic [IRQ_N-1:0] irq_en = 0, irq_req = 0;
  logic [2:0] mode;
  logic cpu_clk_en, hs_clk_stop, ls_clk_stop, wake, wake_svc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_ctrl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic [2:0] m);
    chk(req, {5'd0, mode}, {5'd0, m});
    chk({req, " clocks R7"}, {5'd0, cpu_clk_en, hs_clk_stop, ls_clk_stop},
        {5'd0, m == 3'd0, (m == 3'd2 || m == 3'd3 || m == 3'd4), m == 3'd2});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; irq_en = 0; irq_req = 0; bus_wr = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; bus_addr = 16'hF009;
  endtask

  task automatic wake_up(input logic m, input string req);
    irq_en = 8'h10; irq_req = 8'h10; mie = m;
    @(negedge clk);
    chk({req, " wake"}, {6'd0, wake, wake_svc}, {6'd0, 1'b1, m});
    chk_mode(req, 3'd0);
    irq_req = 0;
    @(negedge clk);
    chk({req, " pulse"}, {7'd0, wake}, 8'd0);
  endtask

  initial begin
    do_reset();
    chk_mode("R1 reset", 3'd0);
    chk("R1 wake", {7'd0, wake}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      stop_unlock = VEC[i][7]; hs_sel = VEC[i][5];
      hs_osc_stat = VEC[i][4]; ls_osc_stat = VEC[i][3];
      if (VEC[i][6]) begin irq_en = 8'h01; irq_req = 8'h01; end
      wr(16'hF009, {4'd0, VEC[i][11:8]});
      chk_mode($sformatf("R2 vector %0d", i), VEC[i][2:0]);
      irq_en = 0; irq_req = 0;
      if (VEC[i][2:0] != 3'd0) wake_up(i[0], "R8");
    end

    // upper data bits ignored
    do_reset(); hs_sel = 1; hs_osc_stat = 0;
    wr(16'hF009, 8'hF1);
    chk_mode("R2 upper bits", 3'd1);
    // write during low-power mode ignored
    stop_unlock = 1;
    wr(16'hF009, 8'h02);
    chk_mode("R9 write in HALT", 3'd1);
    wake_up(1'b0, "R8 no service");
    // other address
    wr(16'hF00A, 8'h01);
    chk_mode("R9 other address", 3'd0);
    // pending with mie=0 still blocks
    mie = 0; irq_en = 8'h80; irq_req = 8'h80;
    wr(16'hF009, 8'h04);
    chk_mode("R5 mie off", 3'd0);
    irq_en = 0; irq_req = 0;
    // enable without request does not block or wake
    irq_en = 8'hFF;
    wr(16'hF009, 8'h08);
    chk_mode("R5 enable only", 3'd4);
    @(negedge clk);
    chk_mode("R8 stays without request", 3'd4);
    wake_up(1'b1, "R8 HALT-H");
    // reset from low-power mode
    wr(16'hF009, 8'h01);
    do_reset();
    chk_mode("R1 reset from HALT", 3'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule